// File: doc/BRIEF.md
# Multi-Link Stream Alignment Gate

This block sits between user logic and a group of parallel serial-link transport cores that have to carry data in lockstep. It retimes the external SYSREF pulse through two register stages and fans the retimed pulse out to every core. On the transmit side, it merges the per-core ready outputs into one ready signal. That signal decides whether a user word is offered to the cores. On the receive side, it merges the per-core valid outputs into one valid signal. That signal decides whether received data reaches the user.

A mode input picks between two behaviours. In 64b/66b mode the merging is active, so no word can pass through one link unless it passes through all of them. In 8b/10b mode the cores are expected to switch ready and valid on the same clock cycle, so each link is gated only by its own signal. A sticky flag records any cycle on which they did not switch together.

User and core data buses are the concatenation of one fixed-width slice per link, with link 0 in the least significant slice. The gating paths are purely combinational, so merging adds no latency. It only holds back the first transfer until the slowest core is ready.

Top module: `mlink_align_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, both SYSREF stages and the lockstep error flag are cleared, so `sysref_out` reads all zeros and `lockstep_err` reads 0 after that edge.
- R2: Every bit of `sysref_out` equals the value `sysref_in` had two clock edges earlier, and all bits are identical.
- R3: With `mode_sel`=0 (64b/66b), `tx_usr_ready` is 1 only when every bit of `tx_core_ready` is 1.
- R4: With `mode_sel`=0, every bit of `tx_core_valid` equals `tx_usr_valid` AND the merged ready. Slice i of `tx_core_data` (bits i*W to i*W+W-1) carries user slice i while `tx_core_valid[i]` is 1 and is zero otherwise. No core is ever offered a word while its own ready is 0.
- R5: With `mode_sel`=0, `rx_usr_valid` is 1 only when every bit of `rx_core_valid` is 1.
- R6: With `mode_sel`=0, `rx_usr_data` is the concatenated core data while `rx_usr_valid` is 1. Otherwise it is all zeros, so partially valid words are discarded.
- R7: With `mode_sel`=1 (8b/10b), `tx_usr_ready` follows `tx_core_ready[0]`. `tx_core_valid[i]` is `tx_usr_valid` AND `tx_core_ready[i]`, and slice i of the data is forwarded only while that bit is 1.
- R8: With `mode_sel`=1, `rx_usr_valid` follows `rx_core_valid[0]`. Slice i of `rx_usr_data` is forwarded while `rx_core_valid[i]` is 1 and is zero otherwise.
- R9: With `mode_sel`=1, a clock edge at which the `tx_core_ready` bits disagree, or the `rx_core_valid` bits disagree, sets `lockstep_err` after that edge. The flag then stays at 1 until reset. In mode 0, disagreement never sets it.
- R10: All gating in R3 to R8 acts in the same cycle as its inputs, with no register between the core signals and the user signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 = 64b/66b merged gating, 1 = 8b/10b per-link pass-through |
| sysref_in | input | 1 | External SYSREF pulse |
| sysref_out | output | NUM_LINKS | Retimed SYSREF, one copy per core |
| tx_usr_data | input | NUM_LINKS*SLICE_W | User transmit words, one slice per link |
| tx_usr_valid | input | 1 | User transmit word present |
| tx_usr_ready | output | 1 | Word accepted by the cores this cycle |
| tx_core_data | output | NUM_LINKS*SLICE_W | Gated transmit data toward the cores |
| tx_core_valid | output | NUM_LINKS | Per-core transmit valid |
| tx_core_ready | input | NUM_LINKS | Per-core transmit ready |
| rx_core_data | input | NUM_LINKS*SLICE_W | Receive data from the cores |
| rx_core_valid | input | NUM_LINKS | Per-core receive valid |
| rx_usr_data | output | NUM_LINKS*SLICE_W | Gated receive data toward the user |
| rx_usr_valid | output | 1 | Receive word valid |
| lockstep_err | output | 1 | Sticky flag: per-link handshakes disagreed in 8b/10b mode |

## Verification
The only state in the block is the SYSREF pipeline and the error flag. A wrong stage value appears on `sysref_out` exactly two edges after the input pulse, as a pulse that is early, late or split across the copies. A flag that sets, clears or fails to hold wrongly appears on `lockstep_err` one edge after the triggering cycle. The gating paths have no state, so a fault there shows in the same cycle as a word that reaches some cores but not others, or as a non-zero receive slice while valid is low. The bench uses three links so that cases where some links are ready and others are not can be told apart from cases where none are ready.

// File: rtl/mlag_pkg.sv
// Package mlag_pkg
// Shared types for the multi-link alignment gate.
// Assumes: mode input is one bit, 0 selects merged gating.
package mlag_pkg;
    typedef enum logic {
        MODE_MERGED = 1'b0,
        MODE_PERLINK = 1'b1
    } gate_mode_e;

    localparam int unsigned SYSREF_STAGES = 2;
endpackage

// File: rtl/mlag_sysref_pipe.sv
// Module mlag_sysref_pipe
// Two-stage retiming of the external SYSREF pulse. The first stage is a single
// boundary register. The second stage is one register per core, so each copy
// can be placed near its consumer.
// Assumes: sysref_in is already in the clk domain. Reset is synchronous, active low.
module mlag_sysref_pipe #(
    parameter int unsigned NUM_LINKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sysref_in,
    output logic [NUM_LINKS-1:0] sysref_out
);
    logic edge_stage;
    logic [1:0] warm_cnt;

    // Boundary capture register
    always_ff @(posedge clk) begin
        if (!rst_n) edge_stage <= 1'b0;
        else        edge_stage <= sysref_in;
    end

    // Replicated fabric stage, one per core
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_fan
        always_ff @(posedge clk) begin
            if (!rst_n) sysref_out[g] <= 1'b0;
            else        sysref_out[g] <= edge_stage;
        end
    end

    // Counts edges since reset so the delay check looks back only over post-reset history
    always_ff @(posedge clk) begin
        if (!rst_n)                               warm_cnt <= 2'd0;
        else if (warm_cnt != mlag_pkg::SYSREF_STAGES) warm_cnt <= warm_cnt + 2'd1;
    end

    // R2: output is the input delayed by exactly two edges
    a_r2_sysref_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2'd2) |-> (sysref_out == {NUM_LINKS{$past(sysref_in, 2)}}));

    // R2: all copies agree
    a_r2_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (sysref_out == '0) || (sysref_out == '1));
endmodule

// File: rtl/mlag_tx_gate.sv
// Module mlag_tx_gate
// Transmit qualification. In merged mode a user word is offered to the cores only
// when all of them are ready. In per-link mode each core is gated by its own ready.
// Assumes: purely combinational. Slice i of the data belongs to link i.
module mlag_tx_gate #(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned SLICE_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  mlag_pkg::gate_mode_e           mode,
    input  logic [NUM_LINKS*SLICE_W-1:0]   usr_data,
    input  logic                           usr_valid,
    output logic                           usr_ready,
    output logic [NUM_LINKS*SLICE_W-1:0]   core_data,
    output logic [NUM_LINKS-1:0]           core_valid,
    input  logic [NUM_LINKS-1:0]           core_ready
);
    logic all_ready;
    logic merged;

    // Merge per-core ready and select the user-facing ready
    always_comb begin
        all_ready = &core_ready;
        merged    = (mode == mlag_pkg::MODE_MERGED);
        usr_ready = merged ? all_ready : core_ready[0];
    end

    // Per-link offer and data qualification
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
        always_comb begin
            core_valid[g] = usr_valid & (merged ? all_ready : core_ready[g]);
            core_data[g*SLICE_W +: SLICE_W] =
                core_valid[g] ? usr_data[g*SLICE_W +: SLICE_W] : '0;
        end
    end

    // R4: no core is offered a word it cannot take
    a_r4_no_orphan_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid & ~core_ready) == '0);

    // R4: merged mode offers to all cores or none
    a_r4_lockstep_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == mlag_pkg::MODE_MERGED) |-> ((core_valid == '0) || (core_valid == '1)));

    // R3: a merged ready implies every core is ready
    a_r3_ready_all: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == mlag_pkg::MODE_MERGED) && usr_ready) |-> (core_ready == '1));
endmodule

// File: rtl/mlag_rx_gate.sv
// Module mlag_rx_gate
// Receive qualification. In merged mode received words reach the user only when
// all cores report valid, and partial words are zeroed. In per-link mode each
// slice is gated by its own valid.
// Assumes: purely combinational. Slice i of the data belongs to link i.
module mlag_rx_gate #(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned SLICE_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  mlag_pkg::gate_mode_e           mode,
    input  logic [NUM_LINKS*SLICE_W-1:0]   core_data,
    input  logic [NUM_LINKS-1:0]           core_valid,
    output logic [NUM_LINKS*SLICE_W-1:0]   usr_data,
    output logic                           usr_valid
);
    logic all_valid;
    logic merged;

    // Merge per-core valid and select the user-facing valid
    always_comb begin
        all_valid = &core_valid;
        merged    = (mode == mlag_pkg::MODE_MERGED);
        usr_valid = merged ? all_valid : core_valid[0];
    end

    // Per-link slice qualification
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
        always_comb begin
            usr_data[g*SLICE_W +: SLICE_W] =
                (merged ? all_valid : core_valid[g]) ? core_data[g*SLICE_W +: SLICE_W] : '0;
        end
    end

    // R6: no partial word leaks out in merged mode
    a_r6_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == mlag_pkg::MODE_MERGED) && !usr_valid) |-> (usr_data == '0));

    // R5: merged valid implies every core valid
    a_r5_valid_all: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == mlag_pkg::MODE_MERGED) && usr_valid) |-> (core_valid == '1));
endmodule

// File: rtl/mlag_agree_mon.sv
// Module mlag_agree_mon
// Sticky detector for per-link handshake disagreement in per-link mode.
// Assumes: the flag is cleared only by the synchronous active-low reset.
module mlag_agree_mon #(
    parameter int unsigned NUM_LINKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  mlag_pkg::gate_mode_e  mode,
    input  logic [NUM_LINKS-1:0]  tx_ready,
    input  logic [NUM_LINKS-1:0]  rx_valid,
    output logic                  err
);
    logic tx_split;
    logic rx_split;

    // Detect vectors that are neither all-zero nor all-one
    always_comb begin
        tx_split = (|tx_ready) & ~(&tx_ready);
        rx_split = (|rx_valid) & ~(&rx_valid);
    end

    // Latch the flag on a disagreement seen in per-link mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if ((mode == mlag_pkg::MODE_PERLINK) && (tx_split || rx_split))
            err <= 1'b1;
    end

    // R9: once set the flag holds until reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);

    // R9: merged mode never raises the flag
    a_r9_quiet_merged: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == mlag_pkg::MODE_MERGED && !$past(err)) |-> !err);
endmodule

// File: rtl/mlink_align_gate.sv
// Module mlink_align_gate
// Top of the multi-link alignment gate: SYSREF retiming and fan-out, transmit
// ready merging, receive valid merging, and a lockstep disagreement flag.
// Assumes: all signals are in the core clock domain. Reset is synchronous, active low.
module mlink_align_gate #(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned SLICE_W   = 32,
    localparam int unsigned BUS_W    = NUM_LINKS * SLICE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_sel,
    input  logic                 sysref_in,
    output logic [NUM_LINKS-1:0] sysref_out,
    input  logic [BUS_W-1:0]     tx_usr_data,
    input  logic                 tx_usr_valid,
    output logic                 tx_usr_ready,
    output logic [BUS_W-1:0]     tx_core_data,
    output logic [NUM_LINKS-1:0] tx_core_valid,
    input  logic [NUM_LINKS-1:0] tx_core_ready,
    input  logic [BUS_W-1:0]     rx_core_data,
    input  logic [NUM_LINKS-1:0] rx_core_valid,
    output logic [BUS_W-1:0]     rx_usr_data,
    output logic                 rx_usr_valid,
    output logic                 lockstep_err
);
    mlag_pkg::gate_mode_e mode;

    // Decode the mode pin into the shared enum
    always_comb mode = mlag_pkg::gate_mode_e'(mode_sel);

    mlag_sysref_pipe #(.NUM_LINKS(NUM_LINKS)) u_sysref (
        .clk        (clk),
        .rst_n      (rst_n),
        .sysref_in  (sysref_in),
        .sysref_out (sysref_out)
    );

    mlag_tx_gate #(.NUM_LINKS(NUM_LINKS), .SLICE_W(SLICE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .usr_data   (tx_usr_data),
        .usr_valid  (tx_usr_valid),
        .usr_ready  (tx_usr_ready),
        .core_data  (tx_core_data),
        .core_valid (tx_core_valid),
        .core_ready (tx_core_ready)
    );

    mlag_rx_gate #(.NUM_LINKS(NUM_LINKS), .SLICE_W(SLICE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .core_data  (rx_core_data),
        .core_valid (rx_core_valid),
        .usr_data   (rx_usr_data),
        .usr_valid  (rx_usr_valid)
    );

    mlag_agree_mon #(.NUM_LINKS(NUM_LINKS)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .tx_ready (tx_core_ready),
        .rx_valid (rx_core_valid),
        .err      (lockstep_err)
    );

    // R10: in merged mode the user ready tracks the current cores with no delay
    a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && tx_core_ready == '1) |-> tx_usr_ready);
endmodule

// File: tb/test_mlink_align_gate.sv
// Directed bench for mlink_align_gate with three links of 8 bits.
module test_mlink_align_gate;
    localparam int N = 3;
    localparam int W = 8;
    localparam int B = N * W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_sel;
    logic         sysref_in;
    logic [N-1:0] sysref_out;
    logic [B-1:0] tx_usr_data;
    logic         tx_usr_valid;
    logic         tx_usr_ready;
    logic [B-1:0] tx_core_data;
    logic [N-1:0] tx_core_valid;
    logic [N-1:0] tx_core_ready;
    logic [B-1:0] rx_core_data;
    logic [N-1:0] rx_core_valid;
    logic [B-1:0] rx_usr_data;
    logic         rx_usr_valid;
    logic         lockstep_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mlink_align_gate #(.NUM_LINKS(N), .SLICE_W(W)) i_mlink_align_gate (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sysref_in(sysref_in),
        .sysref_out(sysref_out), .tx_usr_data(tx_usr_data), .tx_usr_valid(tx_usr_valid),
        .tx_usr_ready(tx_usr_ready), .tx_core_data(tx_core_data),
        .tx_core_valid(tx_core_valid), .tx_core_ready(tx_core_ready),
        .rx_core_data(rx_core_data), .rx_core_valid(rx_core_valid),
        .rx_usr_data(rx_usr_data), .rx_usr_valid(rx_usr_valid),
        .lockstep_err(lockstep_err)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Expected slice gating: keep slice i where mask bit i is set
    function automatic logic [B-1:0] keep(input logic [B-1:0] d, input logic [N-1:0] m);
        logic [B-1:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) r[i*W +: W] = d[i*W +: W];
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sysref_in = 1'b1; mode_sel = 1'b1;
        tx_core_ready = 3'b001; rx_core_valid = 3'b011;
        repeat (3) @(negedge clk);
        chk("R1 sysref cleared", 64'(sysref_out), 64'd0);
        chk("R1 err cleared", 64'(lockstep_err), 64'd0);
        rst_n = 1'b1; sysref_in = 1'b0; mode_sel = 1'b0;
        tx_core_ready = '0; rx_core_valid = '0;
        @(negedge clk);
    endtask

    task automatic t_sysref();
        sysref_in = 1'b1;
        @(negedge clk);
        sysref_in = 1'b0;
        chk("R2 not yet after one edge", 64'(sysref_out), 64'd0);
        @(negedge clk);
        chk("R2 pulse after two edges", 64'(sysref_out), 64'h7);
        @(negedge clk);
        chk("R2 pulse one cycle wide", 64'(sysref_out), 64'd0);
    endtask

    task automatic t_tx_merged();
        logic [N-1:0] pats [4] = '{3'b000, 3'b101, 3'b011, 3'b111};
        mode_sel = 1'b0; tx_usr_data = 24'hC3B2A1; tx_usr_valid = 1'b1;
        foreach (pats[k]) begin
            tx_core_ready = pats[k];
            #1;
            chk("R3 merged ready", 64'(tx_usr_ready), 64'(&pats[k]));
            chk("R4 core valid", 64'(tx_core_valid), (&pats[k]) ? 64'h7 : 64'h0);
            chk("R4 core data", 64'(tx_core_data), (&pats[k]) ? 64'hC3B2A1 : 64'h0);
        end
        tx_usr_valid = 1'b0;
        #1;
        chk("R4 no offer without user valid", 64'(tx_core_valid), 64'd0);
        chk("R10 ready same cycle", 64'(tx_usr_ready), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_rx_merged();
        mode_sel = 1'b0; rx_core_data = 24'h5E4D3C;
        rx_core_valid = 3'b110;
        #1;
        chk("R5 partial valid low", 64'(rx_usr_valid), 64'd0);
        chk("R6 partial word dropped", 64'(rx_usr_data), 64'd0);
        rx_core_valid = 3'b111;
        #1;
        chk("R5 all valid", 64'(rx_usr_valid), 64'd1);
        chk("R6 word passed", 64'(rx_usr_data), 64'h5E4D3C);
        @(negedge clk);
        rx_core_valid = 3'b010; tx_core_ready = 3'b100;
        @(negedge clk);
        chk("R9 merged mode no flag", 64'(lockstep_err), 64'd0);
    endtask

    task automatic t_tx_perlink();
        mode_sel = 1'b1; tx_usr_data = 24'h998877; tx_usr_valid = 1'b1;
        tx_core_ready = 3'b110;
        #1;
        chk("R7 ready follows link0", 64'(tx_usr_ready), 64'd0);
        chk("R7 per-link valid", 64'(tx_core_valid), 64'h6);
        chk("R7 per-link data", 64'(tx_core_data), 64'(keep(24'h998877, 3'b110)));
        tx_core_ready = 3'b111;
        #1;
        chk("R7 ready all", 64'(tx_usr_ready), 64'd1);
    endtask

    task automatic t_rx_perlink();
        mode_sel = 1'b1; rx_core_data = 24'h332211; rx_core_valid = 3'b101;
        #1;
        chk("R8 valid follows link0", 64'(rx_usr_valid), 64'd1);
        chk("R8 per-link data", 64'(rx_usr_data), 64'(keep(24'h332211, 3'b101)));
    endtask

    task automatic t_err();
        // rx is split (101) from t_rx_perlink; align everything first after reset
        do_reset();
        mode_sel = 1'b1; tx_core_ready = 3'b111; rx_core_valid = 3'b000;
        @(negedge clk);
        chk("R9 agree no flag", 64'(lockstep_err), 64'd0);
        tx_core_ready = 3'b011;
        @(negedge clk);
        tx_core_ready = 3'b111;
        chk("R9 tx split sets flag", 64'(lockstep_err), 64'd1);
        repeat (3) @(negedge clk);
        chk("R9 flag sticky", 64'(lockstep_err), 64'd1);
        do_reset();
        chk("R1 reset clears flag", 64'(lockstep_err), 64'd0);
        mode_sel = 1'b1; rx_core_valid = 3'b001;
        @(negedge clk);
        rx_core_valid = 3'b000;
        chk("R9 rx split sets flag", 64'(lockstep_err), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 1'b0; sysref_in = 1'b0;
        tx_usr_data = '0; tx_usr_valid = 1'b0; tx_core_ready = '0;
        rx_core_data = '0; rx_core_valid = '0;
        do_reset();
        t_sysref();
        t_tx_merged();
        t_rx_merged();
        t_tx_perlink();
        t_rx_perlink();
        t_err();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule